// File: doc/BRIEF.md
# Dual-Mode Multiplexed Pixel Input Capture

This block takes pixels from a graphics controller over a 16-bit bus, where every pixel is sent as two successive halves, and rebuilds 32-bit pixel words. The data bus, data-enable and both sync lines are sampled with the same incoming pixel clock.

Two transfer modes are supported. In double-edge mode the pixel clock runs at the pixel rate, and both of its edges capture data. In single-edge mode the pixel clock runs at twice the pixel rate, and only one edge captures data. Configuration inputs set three things: the mode, an inversion of the incoming clock, and which edge is significant. In single-edge mode that edge is the capturing edge. In double-edge mode it is the edge that carries the first half of each pixel.

The whole block runs on one fast system clock, `clk`. The pixel clock is treated as a sampled signal, and its edges are found by comparing successive samples. Each level of the pixel clock, together with the data sent with it, must stay stable for at least two `clk` cycles. Each completed pixel is reported with a single-cycle valid strobe.

Top module: `pxcap_top`

## Requirements
- R1: A synchronous active-high `rst` clears `pix_valid`, `pix_out`, `hs_out`, `vs_out` and any pending half-pixel. After reset, the next capture counts as a first half.
- R2: With `cfg_ddr`=1, the first half of a pixel is captured on the selected edge of the effective clock, and the second half on the opposite edge. `cfg_first_fall`=0 selects the rising edge and 1 selects the falling edge.
- R3: With `cfg_ddr`=0, only the selected edge captures data (`cfg_first_fall`=0 for rising, 1 for falling). Data present at the other edge is ignored. Captured samples alternate between first half and second half.
- R4: The effective clock is `pclk_in` XOR `cfg_invert`. Setting `cfg_invert` therefore swaps which physical edge of `pclk_in` counts as rising.
- R5: The output word is {first half, second half}, with the first half in bits 31:16. It is presented on `pix_out` together with a `pix_valid` pulse one cycle long. `pix_valid` never stays high for two consecutive cycles.
- R6: A pixel is emitted only when a first half is pending and `de_in` was high for both halves. No pixel is emitted while `de_in` is low.
- R7: In single-edge mode, the first sample after `de_in` rises is a first half. A sample taken with `de_in` low discards any pending first half.
- R8: `hs_out` and `vs_out` take the sync levels of each first-half sample, even when `de_in` is low. They are not updated by second-half samples.
- R9: A change of `cfg_ddr`, `cfg_first_fall` or `cfg_invert` discards any pending first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ddr | input | 1 | 1 selects double-edge mode, 0 selects single-edge mode |
| cfg_invert | input | 1 | Inverts the incoming pixel clock |
| cfg_first_fall | input | 1 | Selects the significant edge: 0 for rising, 1 for falling |
| pclk_in | input | 1 | Pixel clock from the controller |
| pix_din | input | 16 | Multiplexed half-pixel data |
| de_in | input | 1 | Data enable |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| pix_out | output | 32 | Assembled pixel word |
| pix_valid | output | 1 | One-cycle strobe for each completed pixel |
| hs_out | output | 1 | Horizontal sync taken from first-half samples |
| vs_out | output | 1 | Vertical sync taken from first-half samples |

## Verification
On every cycle the assertions check the following:
- the strobe is a single-cycle pulse, and it is issued only when a first half was pending;
- the rising and falling detectors never fire together;
- a sync output changes only after a first-half capture;
- a configuration change leaves no pending half;
- reset clears the strobe and the pending state.

The bench scenarios show the rest:
- in each mode, polarity and edge setting, the right halves end up in the right word positions;
- data at the non-capturing edge is ignored;
- a pixel interrupted by data-enable, by a reconfiguration or by a reset is dropped;
- sync levels pass through while data-enable is low.

// File: rtl/pxcap_pkg.sv
package pxcap_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned PIX_W  = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [PIX_W-1:0]  pix_t;

  typedef struct packed {
    half_t data;
    logic  de;
    logic  hs;
    logic  vs;
  } sample_t;

  typedef struct packed {
    logic ddr;
    logic inv;
    logic fall1;
  } cfg_t;

  // first half goes to the upper bits
  function automatic pix_t pack_pixel(input half_t hi, input half_t lo);
    return {hi, lo};
  endfunction

  // edge that captures the first half (DDR) or every half (SDR)
  function automatic logic sel_edge(input logic fall1, input logic rise, input logic fall);
    return fall1 ? fall : rise;
  endfunction
endpackage

// File: rtl/pxcap_edge.sv
module pxcap_edge
  import pxcap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pclk_raw,
  input  logic    inv,
  input  half_t   din,
  input  logic    de,
  input  logic    hs,
  input  logic    vs,
  output logic    rise_evt,
  output logic    fall_evt,
  output sample_t smp
);
  logic pq, pqq;
  logic eff_now, eff_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      pq  <= 1'b0;
      pqq <= 1'b0;
      smp <= '0;
    end else begin
      pq  <= pclk_raw;
      pqq <= pq;
      smp <= '{data: din, de: de, hs: hs, vs: vs};
    end
  end

  // inversion applied to both taps: toggling it creates no edge
  always_comb begin
    eff_now  = pq ^ inv;
    eff_old  = pqq ^ inv;
    rise_evt = eff_now & ~eff_old;
    fall_evt = ~eff_now & eff_old;
  end
endmodule

// File: rtl/pxcap_phase.sv
module pxcap_phase
  import pxcap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg,
  input  logic rise_evt,
  input  logic fall_evt,
  input  logic de_s,
  output logic first_evt,
  output logic second_evt,
  output logic have_first,
  output logic cfg_chg
);
  cfg_t cfg_q;
  logic sel, opp, hf_n;

  always_comb begin
    cfg_chg    = (cfg != cfg_q);
    sel        = sel_edge(cfg.fall1, rise_evt, fall_evt);
    opp        = sel_edge(~cfg.fall1, rise_evt, fall_evt);
    first_evt  = 1'b0;
    second_evt = 1'b0;
    hf_n       = have_first;
    if (cfg_chg) begin
      hf_n = 1'b0;
    end else if (cfg.ddr) begin
      if (sel) begin
        first_evt = 1'b1;
        hf_n      = de_s;
      end else if (opp) begin
        second_evt = have_first & de_s;
        hf_n       = 1'b0;
      end
    end else if (sel) begin
      first_evt  = ~have_first;
      second_evt = have_first & de_s;
      hf_n       = ~have_first & de_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= cfg;
      have_first <= 1'b0;
    end else begin
      cfg_q      <= cfg;
      have_first <= hf_n;
    end
  end
endmodule

// File: rtl/pxcap_asm.sv
module pxcap_asm
  import pxcap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  sample_t smp,
  input  logic    first_evt,
  input  logic    second_evt,
  output pix_t    pix_out,
  output logic    pix_valid,
  output logic    hs_out,
  output logic    vs_out
);
  half_t hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      pix_out   <= '0;
      pix_valid <= 1'b0;
      hs_out    <= 1'b0;
      vs_out    <= 1'b0;
    end else begin
      pix_valid <= second_evt;
      if (first_evt) begin
        hold   <= smp.data;
        hs_out <= smp.hs;
        vs_out <= smp.vs;
      end
      if (second_evt) pix_out <= pack_pixel(hold, smp.data);
    end
  end
endmodule

// File: rtl/pxcap_top.sv
module pxcap_top
  import pxcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ddr,
  input  logic              cfg_invert,
  input  logic              cfg_first_fall,
  input  logic              pclk_in,
  input  logic [HALF_W-1:0] pix_din,
  input  logic              de_in,
  input  logic              hs_in,
  input  logic              vs_in,
  output logic [PIX_W-1:0]  pix_out,
  output logic              pix_valid,
  output logic              hs_out,
  output logic              vs_out
);
  cfg_t    cfg;
  sample_t smp;
  logic    rise_evt, fall_evt;
  logic    first_evt, second_evt, have_first, cfg_chg;

  assign cfg = '{ddr: cfg_ddr, inv: cfg_invert, fall1: cfg_first_fall};

  pxcap_edge u_edge (
    .clk(clk), .rst(rst), .pclk_raw(pclk_in), .inv(cfg_invert),
    .din(pix_din), .de(de_in), .hs(hs_in), .vs(vs_in),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .smp(smp)
  );

  pxcap_phase u_phase (
    .clk(clk), .rst(rst), .cfg(cfg), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .de_s(smp.de), .first_evt(first_evt), .second_evt(second_evt),
    .have_first(have_first), .cfg_chg(cfg_chg)
  );

  pxcap_asm u_asm (
    .clk(clk), .rst(rst), .smp(smp), .first_evt(first_evt), .second_evt(second_evt),
    .pix_out(pix_out), .pix_valid(pix_valid), .hs_out(hs_out), .vs_out(vs_out)
  );
endmodule

// File: rtl/pxcap_chk.sv
module pxcap_chk (
  input logic clk,
  input logic rst,
  input logic cfg_ddr,
  input logic cfg_invert,
  input logic cfg_first_fall,
  input logic pix_valid,
  input logic hs_out,
  input logic vs_out,
  input logic rise_evt,
  input logic fall_evt,
  input logic first_evt,
  input logic have_first
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) $past(rst) |-> (!pix_valid && !have_first));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) pix_valid |=> !pix_valid);

  // R6
  valid_needs_first_chk: assert property (@(posedge clk) disable iff (rst) pix_valid |-> $past(have_first));

  // R2
  edge_excl_chk: assert property (@(posedge clk) disable iff (rst) !(rise_evt && fall_evt));

  // R8
  sync_on_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(hs_out) || !$stable(vs_out)) |-> $past(first_evt));

  // R9
  cfg_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_ddr != $past(cfg_ddr) || cfg_invert != $past(cfg_invert) ||
     cfg_first_fall != $past(cfg_first_fall)) |=> !have_first);
endmodule

bind pxcap_top pxcap_chk i_chk (
  .clk(clk), .rst(rst), .cfg_ddr(cfg_ddr), .cfg_invert(cfg_invert),
  .cfg_first_fall(cfg_first_fall), .pix_valid(pix_valid), .hs_out(hs_out),
  .vs_out(vs_out), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .first_evt(first_evt), .have_first(have_first)
);

// File: tb/test_pxcap_top.sv
module test_pxcap_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_ddr = 1'b1, cfg_invert = 1'b0, cfg_first_fall = 1'b0;
  logic        pclk_in = 1'b0;
  logic [15:0] pix_din = '0;
  logic        de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic [31:0] pix_out;
  logic        pix_valid, hs_out, vs_out;

  int unsigned n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       cur_req = "R2";
  bit          done = 0;
  logic        prev_valid = 1'b0;

  always #2 clk = ~clk;

  pxcap_top i_pxcap_top (
    .clk(clk), .rst(rst), .cfg_ddr(cfg_ddr), .cfg_invert(cfg_invert),
    .cfg_first_fall(cfg_first_fall), .pclk_in(pclk_in), .pix_din(pix_din),
    .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in), .pix_out(pix_out),
    .pix_valid(pix_valid), .hs_out(hs_out), .vs_out(vs_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic eff_level();
    return pclk_in ^ cfg_invert;
  endfunction

  // drive one effective-clock transition with its data, then hold
  task automatic edge_to(input logic lvl, input logic [15:0] d, input logic de,
                         input logic hs, input logic vs);
    @(negedge clk);
    pix_din = d; de_in = de; hs_in = hs; vs_in = vs;
    pclk_in = lvl ^ cfg_invert;
    repeat (4) @(negedge clk);
  endtask

  task automatic ddr_pixel(input logic [15:0] hi, input logic [15:0] lo);
    logic f;
    f = ~cfg_first_fall;
    if (eff_level() == f) edge_to(~f, 16'h0BAD, 1'b0, hs_in, vs_in);
    exp_q.push_back({hi, lo});
    edge_to(f, hi, 1'b1, hs_in, vs_in);
    edge_to(~f, lo, 1'b1, hs_in, vs_in);
  endtask

  task automatic sdr_half(input logic [15:0] d, input logic de);
    logic s;
    s = ~cfg_first_fall;
    // non-capturing edge carries junk data that must be ignored
    if (eff_level() == s) edge_to(~s, ~d, de, hs_in, vs_in);
    edge_to(s, d, de, hs_in, vs_in);
  endtask

  task automatic sdr_pixel(input logic [15:0] hi, input logic [15:0] lo);
    exp_q.push_back({hi, lo});
    sdr_half(hi, 1'b1);
    sdr_half(lo, 1'b1);
  endtask

  task automatic set_cfg(input logic ddr, input logic inv, input logic fall1);
    @(negedge clk);
    cfg_ddr = ddr; cfg_invert = inv; cfg_first_fall = fall1;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, cur_req, "pixels missing", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor: compare each strobe with the scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (pix_valid) begin
        check(!prev_valid, "R5", "strobe longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected pixel", pix_out, 0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(pix_out == e, cur_req, "pixel word", pix_out, e);
        end
      end
      prev_valid <= pix_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pix_valid == 0, "R1", "valid after reset", pix_valid, 0);
    check(pix_out == 0, "R1", "pixel after reset", pix_out, 0);
    check({hs_out, vs_out} == 0, "R1", "sync after reset", {hs_out, vs_out}, 0);

    // R2 R5 double-edge, first half on rising edge
    cur_req = "R2";
    ddr_pixel(16'h1234, 16'h5678);
    ddr_pixel(16'hA5A5, 16'h0F0F);
    ddr_pixel(16'hFFFF, 16'h0001);
    drain();

    // R2 first half on falling edge
    set_cfg(1, 0, 1);
    ddr_pixel(16'hC0DE, 16'hBEEF);
    ddr_pixel(16'h0102, 16'h0304);
    drain();

    // R4 inverted clock polarity
    cur_req = "R4";
    set_cfg(1, 1, 0);
    ddr_pixel(16'h4444, 16'h8888);
    ddr_pixel(16'h9ABC, 16'hDEF0);
    set_cfg(0, 1, 1);
    sdr_pixel(16'h7777, 16'h3333);
    drain();

    // R3 single-edge rising and falling, opposite-edge data ignored
    cur_req = "R3";
    set_cfg(0, 0, 0);
    sdr_pixel(16'h1111, 16'h2222);
    sdr_pixel(16'hAAAA, 16'h5555);
    set_cfg(0, 0, 1);
    sdr_pixel(16'h6060, 16'h0606);
    drain();

    // R7 DE-low sample drops a pending half; pairing restarts after DE rise
    cur_req = "R7";
    set_cfg(0, 0, 0);
    sdr_half(16'hDEAD, 1'b1);
    sdr_half(16'hBEEF, 1'b0);
    sdr_half(16'h0000, 1'b0);
    sdr_pixel(16'hCAFE, 16'hF00D);
    drain();

    // R6 no pixel while DE low in double-edge mode
    cur_req = "R6";
    set_cfg(1, 0, 0);
    edge_to(1, 16'h1357, 1'b0, 0, 0);
    edge_to(0, 16'h2468, 1'b0, 0, 0);
    edge_to(1, 16'h1357, 1'b1, 0, 0);
    edge_to(0, 16'h2468, 1'b0, 0, 0);
    drain();

    // R8 sync from first-half samples while DE low
    edge_to(1, 16'h0, 1'b0, 1, 1);
    check(hs_out == 1, "R8", "hs after first half", hs_out, 1);
    check(vs_out == 1, "R8", "vs after first half", vs_out, 1);
    edge_to(0, 16'h0, 1'b0, 0, 0);
    check(hs_out == 1, "R8", "hs held on second half", hs_out, 1);
    edge_to(1, 16'h0, 1'b0, 0, 1);
    check({hs_out, vs_out} == 2'b01, "R8", "sync update", {hs_out, vs_out}, 2'b01);
    edge_to(0, 16'h0, 1'b0, 0, 1);

    // R9 reconfiguration drops a pending half
    cur_req = "R9";
    set_cfg(0, 0, 0);
    sdr_half(16'h9999, 1'b1);
    set_cfg(0, 0, 1);
    sdr_pixel(16'h4321, 16'h8765);
    drain();

    // R1 reset drops a pending half
    cur_req = "R1";
    sdr_half(16'hEEEE, 1'b1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check(pix_out == 0, "R1", "pixel cleared by reset", pix_out, 0);
    sdr_pixel(16'h2B2B, 16'h3C3C);
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule